// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block connects two 8-bit buses, called A and B. Data can go from A to B or from B to A. For each direction, the data sent is either the live value on the opposite bus or a value captured earlier. The captured value is held in a register for that direction, and each register has its own capture strobe. An active-low output enable and a direction input decide which bus, if either, the block drives.

Each bus is modelled as a separate input vector, output vector and output-enable flag, with no tristate nets. The capture strobes are sampled on the single system clock, and a register loads on the first system-clock edge at which its strobe is seen high after being seen low. Both registers keep loading while the outputs are isolated. Two instances side by side give a 16-bit transceiver.

Top module: `dual_bus_xcvr`

## Requirements
- R1: While `rstN` is low, `aOe` and `bOe` are both 0. Reset clears both storage registers to zero.
- R2: When `outEnN` is 1, `aOe` and `bOe` are both 0, whatever the other control inputs are.
- R3: When `outEnN` is 0 and `dirAtoB` is 1, `bOe` is 1 and `aOe` is 0.
- R4: When `outEnN` is 0 and `dirAtoB` is 0, `aOe` is 1 and `bOe` is 0.
- R5: While `bOe` is 1 and `selStoredB` is 0, `bOut` equals `aIn` in the same cycle. While `aOe` is 1 and `selStoredA` is 0, `aOut` equals `bIn` in the same cycle.
- R6: While `bOe` is 1 and `selStoredB` is 1, `bOut` equals the A-to-B storage register.
- R7: While `aOe` is 1 and `selStoredA` is 1, `aOut` equals the B-to-A storage register.
- R8: The A-to-B register loads `aIn` at a system-clock edge where `clkAtoB` is 1 and was 0 at the previous edge. At all other edges it holds, including while `clkAtoB` stays high.
- R9: The B-to-A register loads `bIn` at a system-clock edge where `clkBtoA` is 1 and was 0 at the previous edge. At all other edges it holds.
- R10: Both registers capture as in R8 and R9 while `outEnN` is 1. The captured values then appear on the outputs once they are enabled.
- R11: `aOe` and `bOe` are never 1 in the same cycle.
- R12: An output whose enable is 0 reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| outEnN | input | 1 | Active-low output enable for both buses |
| dirAtoB | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| selStoredB | input | 1 | 1: B output takes the A-to-B register; 0: live A input |
| selStoredA | input | 1 | 1: A output takes the B-to-A register; 0: live B input |
| clkAtoB | input | 1 | Capture strobe for the A-to-B register (rising edge) |
| clkBtoA | input | 1 | Capture strobe for the B-to-A register (rising edge) |
| aIn | input | WIDTH | A bus input value |
| aOut | output | WIDTH | Value driven onto the A bus |
| aOe | output | 1 | A bus driver enable |
| bIn | input | WIDTH | B bus input value |
| bOut | output | WIDTH | Value driven onto the B bus |
| bOe | output | 1 | B bus driver enable |

## Verification
The bench walks all sixteen settings of enable, direction and the two selects, using two different data patterns. A swapped select or direction shows up as the wrong bus enabled or the wrong source on the output. Captures are made while the outputs are isolated and then read back. A design that gated loading with the output enable would return stale data there. A capture strobe is held high across several clocks while the input changes. A level-sensitive load would follow the input instead of keeping the first value. The bench also drives the buses during reset and checks the enables stay low, catching a design that lets the outputs come up driven.

// File: rtl/dual_bus_xcvr_pkg.sv
package dual_bus_xcvr_pkg;
  typedef struct packed {
    logic loadAtoB;
    logic loadBtoA;
    logic driveA;
    logic driveB;
    logic storedToB;
    logic storedToA;
  } xcvrStrobes_t;
endpackage

// File: rtl/dual_bus_xcvr_ctrl.sv
module dual_bus_xcvr_ctrl
  import dual_bus_xcvr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         outEnN,
  input  logic         dirAtoB,
  input  logic         selStoredB,
  input  logic         selStoredA,
  input  logic         clkAtoB,
  input  logic         clkBtoA,
  output xcvrStrobes_t strobes
);
  localparam int NumChan = 2;

  logic [NumChan-1:0] capLevel;
  logic [NumChan-1:0] capPrev;
  logic [NumChan-1:0] capRise;

  assign capLevel = {clkBtoA, clkAtoB};

  // Edge detectors; the previous level tracks even in reset so that a
  // strobe sitting high through reset does not count as a new edge.
  for (genvar ch = 0; ch < NumChan; ch++) begin : g_edge
    always_ff @(posedge clk) begin
      capPrev[ch] <= capLevel[ch];
    end
    assign capRise[ch] = capLevel[ch] & ~capPrev[ch];
  end

  logic outputsOn;
  assign outputsOn = rstN & ~outEnN;

  always_comb begin
    strobes           = '0;
    strobes.loadAtoB  = rstN & capRise[0];
    strobes.loadBtoA  = rstN & capRise[1];
    strobes.driveB    = outputsOn & dirAtoB;
    strobes.driveA    = outputsOn & ~dirAtoB;
    strobes.storedToB = selStoredB;
    strobes.storedToA = selStoredA;
  end

  assert_edge_ab_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadAtoB |-> (clkAtoB && !$past(clkAtoB)));
  assert_edge_ba_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadBtoA |-> (clkBtoA && !$past(clkBtoA)));
endmodule

// File: rtl/dual_bus_xcvr_dp.sv
module dual_bus_xcvr_dp
  import dual_bus_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  xcvrStrobes_t     strobes,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe
);
  logic [WIDTH-1:0] regAtoB;
  logic [WIDTH-1:0] regBtoA;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regAtoB <= '0;
      regBtoA <= '0;
    end else begin
      if (strobes.loadAtoB) regAtoB <= aIn;
      if (strobes.loadBtoA) regBtoA <= bIn;
    end
  end

  logic [WIDTH-1:0] srcToB;
  logic [WIDTH-1:0] srcToA;

  assign srcToB = strobes.storedToB ? regAtoB : aIn;
  assign srcToA = strobes.storedToA ? regBtoA : bIn;

  assign bOe  = strobes.driveB;
  assign aOe  = strobes.driveA;
  assign bOut = strobes.driveB ? srcToB : '0;
  assign aOut = strobes.driveA ? srcToA : '0;

  assert_load_ab_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadAtoB |=> (regAtoB == $past(aIn)));
  assert_hold_ab_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadAtoB |=> $stable(regAtoB));
  assert_load_ba_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadBtoA |=> (regBtoA == $past(bIn)));
  assert_hold_ba_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadBtoA |=> $stable(regBtoA));
endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr
  import dual_bus_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             outEnN,
  input  logic             dirAtoB,
  input  logic             selStoredB,
  input  logic             selStoredA,
  input  logic             clkAtoB,
  input  logic             clkBtoA,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe
);
  xcvrStrobes_t strobes;

  dual_bus_xcvr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .outEnN     (outEnN),
    .dirAtoB    (dirAtoB),
    .selStoredB (selStoredB),
    .selStoredA (selStoredA),
    .clkAtoB    (clkAtoB),
    .clkBtoA    (clkBtoA),
    .strobes    (strobes)
  );

  dual_bus_xcvr_dp #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .aIn     (aIn),
    .bIn     (bIn),
    .aOut    (aOut),
    .aOe     (aOe),
    .bOut    (bOut),
    .bOe     (bOe)
  );

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(aOe && bOe));
  assert_iso_R2: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> (!aOe && !bOe));
  assert_quiet_a_R12: assert property (@(posedge clk) disable iff (!rstN)
    !aOe |-> (aOut == '0));
  assert_quiet_b_R12: assert property (@(posedge clk) disable iff (!rstN)
    !bOe |-> (bOut == '0));
  assert_reset_R1: assert property (@(posedge clk)
    !rstN |-> (!aOe && !bOe));
endmodule

// File: tb/dual_bus_xcvr_tb.sv
`timescale 1ns/1ps
module dual_bus_xcvr_tb;
  localparam int WIDTH = 8;

  logic             clk = 1'b0;
  logic             rstN;
  logic             outEnN, dirAtoB, selStoredB, selStoredA, clkAtoB, clkBtoA;
  logic [WIDTH-1:0] aIn, bIn, aOut, bOut;
  logic             aOe, bOe;

  int vectors = 0;
  int misses  = 0;
  logic [WIDTH-1:0] refAB, refBA;

  always #2.5 clk = ~clk;

  dual_bus_xcvr #(.WIDTH(WIDTH)) u_dut (
    .clk(clk), .rstN(rstN), .outEnN(outEnN), .dirAtoB(dirAtoB),
    .selStoredB(selStoredB), .selStoredA(selStoredA),
    .clkAtoB(clkAtoB), .clkBtoA(clkBtoA),
    .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference model of the outputs from the requirements.
  task automatic checkOutputs(input string req);
    logic expAOe, expBOe;
    logic [WIDTH-1:0] expA, expB;
    expBOe = rstN && !outEnN && dirAtoB;    // R2 R3
    expAOe = rstN && !outEnN && !dirAtoB;   // R2 R4
    expB = expBOe ? (selStoredB ? refAB : aIn) : '0;  // R5 R6 R12
    expA = expAOe ? (selStoredA ? refBA : bIn) : '0;  // R5 R7 R12
    chk(req, "aOe", 32'(aOe), 32'(expAOe));
    chk(req, "bOe", 32'(bOe), 32'(expBOe));
    chk(req, "aOut", 32'(aOut), 32'(expA));
    chk(req, "bOut", 32'(bOut), 32'(expB));
    chk("R11", "oe exclusive", 32'(aOe && bOe), 32'd0);
  endtask

  // Drive a rising strobe at a negedge; the register loads at the next posedge.
  task automatic pulseCapture(input logic doAB, input logic doBA,
                              input logic [WIDTH-1:0] va, input logic [WIDTH-1:0] vb);
    @(negedge clk);
    aIn = va; bIn = vb;
    clkAtoB = doAB; clkBtoA = doBA;
    @(negedge clk);
    if (doAB) refAB = va;
    if (doBA) refBA = vb;
    clkAtoB = 1'b0; clkBtoA = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0; outEnN = 1'b0; dirAtoB = 1'b1; selStoredB = 1'b0; selStoredA = 1'b0;
    clkAtoB = 1'b0; clkBtoA = 1'b0; aIn = 8'hA5; bIn = 8'h5A;
    refAB = '0; refBA = '0;
    repeat (3) @(negedge clk);
    chk("R1", "bOe in reset", 32'(bOe), 32'd0);
    dirAtoB = 1'b0; #1;
    chk("R1", "aOe in reset", 32'(aOe), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    selStoredA = 1'b1; selStoredB = 1'b1; dirAtoB = 1'b0; #1;
    chk("R1", "cleared BtoA reg", 32'(aOut), 32'd0);
    dirAtoB = 1'b1; #1;
    chk("R1", "cleared AtoB reg", 32'(bOut), 32'd0);
    checkOutputs("R1");
  endtask

  task automatic testSweep(input logic [WIDTH-1:0] va, input logic [WIDTH-1:0] vb);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      {outEnN, dirAtoB, selStoredB, selStoredA} = 4'(c);
      aIn = va; bIn = vb;
      #1;
      checkOutputs("R2-R7 sweep");
      if (!outEnN && dirAtoB)  chk("R3", "b driven", 32'(bOe), 32'd1);
      if (!outEnN && !dirAtoB) chk("R4", "a driven", 32'(aOe), 32'd1);
      if (outEnN) chk("R2", "isolated", 32'({aOe, bOe}), 32'd0);
    end
  endtask

  task automatic testLiveFollow();
    outEnN = 1'b0; dirAtoB = 1'b1; selStoredB = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      aIn = 8'(8'h11 * (i + 3)); #1;
      chk("R5", "bOut follows aIn", 32'(bOut), 32'(aIn));
    end
    dirAtoB = 1'b0; selStoredA = 1'b0;
    bIn = 8'h3C; #1;
    chk("R5", "aOut follows bIn", 32'(aOut), 32'h3C);
  endtask

  task automatic testCaptureIsolated();
    outEnN = 1'b1;
    pulseCapture(1'b1, 1'b1, 8'hC3, 8'h96);
    aIn = 8'h00; bIn = 8'hFF; #1;
    checkOutputs("R10");
    outEnN = 1'b0; selStoredB = 1'b1; selStoredA = 1'b1; dirAtoB = 1'b1; #1;
    chk("R10", "AtoB captured isolated", 32'(bOut), 32'hC3);
    dirAtoB = 1'b0; #1;
    chk("R10", "BtoA captured isolated", 32'(aOut), 32'h96);
  endtask

  task automatic testHoldHigh();
    outEnN = 1'b0; dirAtoB = 1'b1; selStoredB = 1'b1;
    @(negedge clk);
    aIn = 8'h42; clkAtoB = 1'b1;
    @(negedge clk);
    refAB = 8'h42;
    for (int i = 0; i < 4; i++) begin
      aIn = 8'(8'h70 + i);
      @(negedge clk);
      #1;
      chk("R8", "no reload while strobe high", 32'(bOut), 32'h42);
    end
    clkAtoB = 1'b0;
    @(negedge clk);
    chk("R8", "still held after strobe low", 32'(bOut), 32'h42);
    // B-to-A captured while B is an input and A is driven.
    dirAtoB = 1'b0; selStoredA = 1'b1;
    pulseCapture(1'b0, 1'b1, 8'h01, 8'hE7);
    #1;
    chk("R9", "BtoA capture while A driven", 32'(aOut), 32'hE7);
    checkOutputs("R9");
  endtask

  initial begin
    #(200000 * 5);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    testReset();
    pulseCapture(1'b1, 1'b1, 8'h5D, 8'hB2);   // R8 R9
    testSweep(8'h81, 8'h7E);
    pulseCapture(1'b1, 1'b1, 8'h29, 8'hD4);
    testSweep(8'hF0, 8'h0F);
    testLiveFollow();
    testCaptureIsolated();
    testHoldHigh();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule